// File: doc/BRIEF.md
# Vectored Trap and Interrupt Unit

This block is the machine-mode trap controller of a small pipelined 32-bit core. Its request vector carries eight sources: two memory-fault exceptions (data side on index 0, instruction side on index 1), three timers on indices 2 to 4 and three pushbuttons on indices 5 to 7. A source asks for service when its request line goes from low to high. The request then stays latched until it is taken. A latched request is eligible only when the global enable bit is set, its own bit in the enable mask is set, and no other trap is being serviced. Among the eligible requests, the lowest index wins.

To take a trap, the unit writes the winning index into the cause register and stores the core's current PC as the return address. It then raises a one-cycle redirect strobe whose target is the vector base plus four times the cause. Exceptions and interrupts share one mask, one cause numbering and one vector table. The pipeline uses the strobe to flush younger instructions. A return instruction produces a second strobe that targets the saved PC and ends the service period.

Software reaches the five control registers through a CSR read/write port that uses the standard machine-mode addresses. Read data is registered.

Top module: `trap_unit`

## Requirements
- R1: After reset, the status register (0x300), enable mask (0x304), return PC (0x341) and cause (0x342) all read as zero, `redirect_o` is low and no request is latched.
- R2: A CSR write stores into the addressed register and a CSR read returns its value on `csr_rdata` in the cycle after `csr_rd_en`. The vector base (0x305) reads with bits 1:0 forced to zero. The status register holds only bit 3, which is the global enable. The mask holds only bits 7:0. The cause register holds only bits 2:0.
- R3: A request is latched on a 0-to-1 transition of its line. A line held high causes exactly one trap.
- R4: No trap is taken while status bit 3 is clear or while the source's mask bit is clear. A request latched during that time stays latched and is taken once it is enabled.
- R5: When several eligible requests are latched, the lowest index is served first and the rest are served in ascending order.
- R6: A trap is taken on the clock edge after the edge that latches its request. `redirect_o` is then high for exactly one cycle with `target_o` = vector base + 4 × index. The cause register holds the index and the return PC holds the `pc_i` value sampled at that edge. A trap update beats a CSR write to the same register in the same cycle.
- R7: From the time a trap is taken until `mret_i`, no other trap is taken, but new requests are still latched.
- R8: `mret_i` produces a one-cycle redirect to the saved return PC and ends the service period. A taken request is no longer latched, so it does not fire again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | NSRC | Request lines, index 0 has highest priority |
| pc_i | input | XLEN | PC of the instruction being interrupted |
| csr_wr_en | input | 1 | CSR write strobe |
| csr_rd_en | input | 1 | CSR read strobe |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | Registered CSR read data |
| mret_i | input | 1 | Return-from-trap executed |
| redirect_o | output | 1 | One-cycle fetch redirect and flush strobe |
| target_o | output | XLEN | Redirect target PC |

## Verification
The bench builds the block with its default sizes: eight sources and a 32-bit datapath. With these sizes every cause value from 0 to 7 can occur, vector offsets reach 28 bytes, and the mask has exactly one bit per source. Random mask values, pulse patterns, vector bases and PCs make the unit drain mixed backlogs in priority order. Some of these backlogs include requests latched while they were masked. Directed cases cover held levels, the global enable being clear, and new requests arriving during a service period.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int CSR_AW = 12;
  localparam logic [CSR_AW-1:0] A_STATUS = 12'h300;
  localparam logic [CSR_AW-1:0] A_MASK   = 12'h304;
  localparam logic [CSR_AW-1:0] A_VBASE  = 12'h305;
  localparam logic [CSR_AW-1:0] A_RETPC  = 12'h341;
  localparam logic [CSR_AW-1:0] A_CAUSE  = 12'h342;
  localparam int GIE_BIT = 3;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STATUS, SEL_MASK, SEL_VBASE, SEL_RETPC, SEL_CAUSE
  } csr_sel_e;

  function automatic csr_sel_e csr_decode(logic [CSR_AW-1:0] a);
    case (a)
      A_STATUS: return SEL_STATUS;
      A_MASK:   return SEL_MASK;
      A_VBASE:  return SEL_VBASE;
      A_RETPC:  return SEL_RETPC;
      A_CAUSE:  return SEL_CAUSE;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/trap_pending.sv
module trap_pending #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] rise;

  assign rise = req_i & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= req_i;
  end

  // A fresh edge on the same cycle as a clear keeps the bit latched.
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           pend_o[i] <= 1'b0;
      else if (rise[i])  pend_o[i] <= 1'b1;
      else if (clr_i[i]) pend_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter #(
  parameter  int NSRC = 8,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] req_i,
  output logic [NSRC-1:0] grant_o,
  output logic [IDXW-1:0] idx_o,
  output logic            any_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_grant
    if (i == 0) begin : g_first
      assign grant_o[i] = req_i[i];
    end else begin : g_rest
      assign grant_o[i] = req_i[i] & ~(|req_i[i-1:0]);
    end
  end

  always_comb begin
    idx_o = '0;
    for (int k = 0; k < NSRC; k++)
      if (grant_o[k]) idx_o = idx_o | IDXW'(k);
  end

  assign any_o = |req_i;
endmodule

// File: rtl/trap_csr.sv
module trap_csr
  import trap_pkg::*;
#(
  parameter  int NSRC = 8,
  parameter  int XLEN = 32,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [CSR_AW-1:0] addr,
  input  logic [XLEN-1:0]   wdata,
  input  logic              take_i,
  input  logic [IDXW-1:0]   cause_i,
  input  logic [XLEN-1:0]   pc_i,
  output logic [XLEN-1:0]   rdata_o,
  output logic [XLEN-1:0]   vbase_o,
  output logic [XLEN-1:0]   retpc_o,
  output logic [NSRC-1:0]   mask_o,
  output logic              gie_o
);
  logic [IDXW-1:0] cause_q;
  logic [XLEN-1:0] rd_mux;
  csr_sel_e        sel;

  assign sel = csr_decode(addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      vbase_o <= '0;
      retpc_o <= '0;
      mask_o  <= '0;
      gie_o   <= 1'b0;
      cause_q <= '0;
    end else begin
      if (wr_en) begin
        case (sel)
          SEL_STATUS: gie_o   <= wdata[GIE_BIT];
          SEL_MASK:   mask_o  <= wdata[NSRC-1:0];
          SEL_VBASE:  vbase_o <= {wdata[XLEN-1:2], 2'b00};
          SEL_RETPC:  retpc_o <= wdata;
          SEL_CAUSE:  cause_q <= wdata[IDXW-1:0];
          default:    ;
        endcase
      end
      // Trap entry is assigned last so it overrides a same-cycle write.
      if (take_i) begin
        retpc_o <= pc_i;
        cause_q <= cause_i;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_STATUS: rd_mux[GIE_BIT] = gie_o;
      SEL_MASK:   rd_mux[NSRC-1:0] = mask_o;
      SEL_VBASE:  rd_mux = vbase_o;
      SEL_RETPC:  rd_mux = retpc_o;
      SEL_CAUSE:  rd_mux[IDXW-1:0] = cause_q;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_o <= '0;
    else if (rd_en) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/trap_unit.sv
module trap_unit
  import trap_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   irq_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              csr_wr_en,
  input  logic              csr_rd_en,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  input  logic              mret_i,
  output logic              redirect_o,
  output logic [XLEN-1:0]   target_o
);
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] pend_w, elig_w, grant_w;
  logic [IDXW-1:0] cause_w;
  logic            take_w, gie_w, busy_q;
  logic [NSRC-1:0] mask_w;
  logic [XLEN-1:0] vbase_w, retpc_w;

  trap_pending #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst(rst), .req_i(irq_i), .clr_i(grant_w), .pend_o(pend_w)
  );

  assign elig_w = pend_w & mask_w & {NSRC{gie_w & ~busy_q & ~mret_i}};

  trap_arbiter #(.NSRC(NSRC)) u_arb (
    .req_i(elig_w), .grant_o(grant_w), .idx_o(cause_w), .any_o(take_w)
  );

  trap_csr #(.NSRC(NSRC), .XLEN(XLEN)) u_csr (
    .clk(clk), .rst(rst), .wr_en(csr_wr_en), .rd_en(csr_rd_en),
    .addr(csr_addr), .wdata(csr_wdata), .take_i(take_w), .cause_i(cause_w),
    .pc_i(pc_i), .rdata_o(csr_rdata), .vbase_o(vbase_w), .retpc_o(retpc_w),
    .mask_o(mask_w), .gie_o(gie_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      redirect_o <= 1'b0;
      target_o   <= '0;
    end else begin
      redirect_o <= take_w | mret_i;
      if (take_w) begin
        busy_q   <= 1'b1;
        target_o <= vbase_w + (XLEN'(cause_w) << 2);
      end else if (mret_i) begin
        busy_q   <= 1'b0;
        target_o <= retpc_w;
      end
    end
  end
endmodule

// File: rtl/trap_unit_chk.sv
module trap_unit_chk #(
  parameter  int NSRC = 8,
  parameter  int XLEN = 32,
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic            take,
  input logic [NSRC-1:0] grant,
  input logic [IDXW-1:0] cause,
  input logic [XLEN-1:0] pc_i,
  input logic            gie,
  input logic            busy,
  input logic            mret_i,
  input logic            redirect_o,
  input logic [XLEN-1:0] target_o,
  input logic [XLEN-1:0] vbase,
  input logic [XLEN-1:0] retpc
);
  logic [XLEN-1:0] offset;
  assign offset = XLEN'(cause) << 2;

  p_gate_r4: assert property (@(posedge clk) disable iff (rst)
    take |-> gie);

  p_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  p_entry_r6: assert property (@(posedge clk) disable iff (rst)
    take |=> redirect_o && target_o == $past(vbase) + $past(offset)
             && retpc == $past(pc_i));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> !take);

  p_return_r8: assert property (@(posedge clk) disable iff (rst)
    mret_i |=> redirect_o && target_o == $past(retpc) && !busy);
endmodule

bind trap_unit trap_unit_chk #(.NSRC(NSRC), .XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .take(take_w), .grant(grant_w), .cause(cause_w),
  .pc_i(pc_i), .gie(gie_w), .busy(busy_q), .mret_i(mret_i),
  .redirect_o(redirect_o), .target_o(target_o), .vbase(vbase_w),
  .retpc(retpc_w)
);

// File: tb/tb_trap_unit.sv
module tb_trap_unit;
  localparam int NSRC = 8;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] irq_i = '0;
  logic [XLEN-1:0] pc_i = '0;
  logic            csr_wr_en = 1'b0, csr_rd_en = 1'b0, mret_i = 1'b0;
  logic [11:0]     csr_addr = '0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [XLEN-1:0] csr_rdata, target_o;
  logic            redirect_o;

  int total = 0, fails = 0;
  bit done = 0;

  logic [NSRC-1:0] pend_m = '0, mie_m = '0;
  bit              gie_m = 0;
  logic [XLEN-1:0] vbase_m = '0, pc_m = '0;

  always #2.5 clk = ~clk;

  trap_unit #(.NSRC(NSRC), .XLEN(XLEN)) dut (
    .clk(clk), .rst(rst), .irq_i(irq_i), .pc_i(pc_i),
    .csr_wr_en(csr_wr_en), .csr_rd_en(csr_rd_en), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mret_i(mret_i),
    .redirect_o(redirect_o), .target_o(target_o)
  );

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int lowest(logic [NSRC-1:0] v);
    for (int i = 0; i < NSRC; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic csr_write(logic [11:0] a, logic [XLEN-1:0] d);
    csr_addr = a; csr_wdata = d; csr_wr_en = 1'b1;
    @(negedge clk);
    csr_wr_en = 1'b0;
  endtask

  task automatic csr_read(logic [11:0] a, output logic [XLEN-1:0] d);
    csr_addr = a; csr_rd_en = 1'b1;
    @(negedge clk);
    csr_rd_en = 1'b0;
    d = csr_rdata;
  endtask

  task automatic pulse(logic [NSRC-1:0] v);
    irq_i = v;
    @(negedge clk);
    irq_i = '0;
    pend_m |= v;
  endtask

  task automatic no_redirect(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(redirect_o === 1'b0, req, "unexpected redirect", 32'(redirect_o), 0);
    end
  endtask

  task automatic expect_trap(int idx, string req);
    logic [XLEN-1:0] v;
    @(negedge clk);
    chk(redirect_o === 1'b1, req, "redirect on trap entry", 32'(redirect_o), 1);
    chk(target_o === vbase_m + 32'(idx) * 4, "R6", "vector target", target_o, vbase_m + 32'(idx) * 4);
    csr_read(12'h342, v);
    chk(redirect_o === 1'b0, "R6", "strobe lasts one cycle", 32'(redirect_o), 0);
    chk(v === 32'(idx), req, "cause index", v, 32'(idx));
    csr_read(12'h341, v);
    chk(v === pc_m, "R6", "saved return PC", v, pc_m);
  endtask

  task automatic do_mret();
    mret_i = 1'b1;
    @(negedge clk);
    mret_i = 1'b0;
    chk(redirect_o === 1'b1, "R8", "return redirect", 32'(redirect_o), 1);
    chk(target_o === pc_m, "R8", "return target", target_o, pc_m);
  endtask

  task automatic drain(string req);
    while (gie_m && ((pend_m & mie_m) != 0)) begin
      int k = lowest(pend_m & mie_m);
      expect_trap(k, req);
      pend_m[k] = 1'b0;
      do_mret();
    end
    no_redirect(1, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [XLEN-1:0] v;
    void'($urandom(32'h1badf00d));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    chk(redirect_o === 1'b0, "R1", "redirect after reset", 32'(redirect_o), 0);
    csr_read(12'h300, v); chk(v === 0, "R1", "status", v, 0);
    csr_read(12'h304, v); chk(v === 0, "R1", "mask", v, 0);
    csr_read(12'h341, v); chk(v === 0, "R1", "return PC", v, 0);
    csr_read(12'h342, v); chk(v === 0, "R1", "cause", v, 0);

    // R2: register widths and read path
    csr_write(12'h305, 32'h0000_1003); vbase_m = 32'h0000_1000;
    csr_read(12'h305, v); chk(v === 32'h1000, "R2", "vector base masked", v, 32'h1000);
    csr_write(12'h300, 32'hFFFF_FFFF);
    csr_read(12'h300, v); chk(v === 32'h8, "R2", "status only enable bit", v, 32'h8);
    csr_write(12'h304, 32'hFFFF_FFFF); mie_m = 8'hFF;
    csr_read(12'h304, v); chk(v === 32'hFF, "R2", "mask width", v, 32'hFF);
    csr_write(12'h341, 32'h0000_1234);
    csr_read(12'h341, v); chk(v === 32'h1234, "R2", "return PC write", v, 32'h1234);
    csr_write(12'h342, 32'hFFFF_FFFF);
    csr_read(12'h342, v); chk(v === 32'h7, "R2", "cause width", v, 32'h7);
    csr_write(12'h300, 0); gie_m = 0;

    // R4: global enable clear, request retained
    pc_m = 32'h0000_0400; pc_i = pc_m;
    pulse(8'h04);
    no_redirect(3, "R4");
    csr_write(12'h300, 32'h8); gie_m = 1;
    drain("R4");
    // R4: per-source mask clear, request retained
    csr_write(12'h304, 32'h01); mie_m = 8'h01;
    pulse(8'h40);
    no_redirect(3, "R4");
    csr_write(12'h304, 32'h41); mie_m = 8'h41;
    drain("R4");

    // R3: held level gives one trap
    csr_write(12'h304, 32'hFF); mie_m = 8'hFF;
    irq_i = 8'h01;
    @(negedge clk);
    expect_trap(0, "R3");
    do_mret();
    no_redirect(4, "R3");
    irq_i = '0;
    no_redirect(2, "R3");

    // R5: simultaneous requests in ascending order
    pulse(8'hA4);
    drain("R5");

    // R7: request during service waits for return
    pc_m = 32'h0000_0800; pc_i = pc_m;
    pulse(8'h10);
    expect_trap(4, "R7"); pend_m[4] = 1'b0;
    pulse(8'h02);
    no_redirect(3, "R7");
    do_mret();
    drain("R7");

    // R5: random backlogs against the priority model
    for (int it = 0; it < 40; it++) begin
      csr_write(12'h300, 0); gie_m = 0;
      if (it % 4 == 0) begin
        vbase_m = $urandom() & 32'hFFFF_FFFC;
        csr_write(12'h305, vbase_m | 32'($urandom() & 3));
      end
      mie_m = NSRC'($urandom());
      csr_write(12'h304, 32'(mie_m));
      pc_m = $urandom() & 32'hFFFF_FFFC; pc_i = pc_m;
      pulse(NSRC'($urandom()));
      csr_write(12'h300, 32'h8); gie_m = 1;
      drain("R5");
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule